// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns a DMA address issued by a PCI device into a system memory address. Single-address-cycle requests (addresses that fit in 32 bits) are compared against a set of programmable windows. Each window has an enable bit, a base, a size mask and a translated base. A window that hits either maps the address directly, or reads a 64-bit page table entry from system memory and builds an 8 KB page translation from it. An optional hole in the low megabyte blocks window matching. Dual-address-cycle requests are served in two ways. A fixed large window can pass the address through with its upper bits dropped. The last window can also run in dual-cycle scatter-gather mode.

Requests arrive one at a time over a valid/ready port. Each response carries a permission flag, the translated address and the mask of address bits that the translation covers. Page table entries are read over a simple request/return-data memory port. Configuration is written through a select-and-data write port.

Top module: `dma_xlat_top`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, mem_req_o is 0, and every window is disabled, so any single-cycle request gets rsp_ok_o=0.
- R2: Configuration writes use cfg_kind_i (0 base, 1 mask, 2 translated base, 3 control) and cfg_win_i (window index). A base keeps data bits 31:20, bit 1 (scatter-gather) and bit 0 (enable). A mask keeps bits 31:20. A translated base keeps bits 34:10. For the last window, bit 39 (dual-cycle enable) is also kept and bit 1 always reads as 1. Control keeps bit 5 (hole) and bit 6 (large window).
- R3: With ext = mask | 0xFFFFF, an enabled window hits when (addr & ~ext) == base[31:20]<<20. A direct hit returns rsp_ok_o=1, address (tbase & ~ext) | (addr & ext), and mask ext.
- R4: A scatter-gather hit reads the entry at (tbase & ~(mask>>10)) | ((addr & (mask|0xFE000))>>10). A valid entry returns address (entry[21:1]<<13) | addr[12:0] and mask 0x1FFF.
- R5: An entry with bit 0 clear returns rsp_ok_o=0.
- R6: For single-cycle requests, windows 0 to NWIN-2 are checked in order, and the lowest-numbered window that hits is used.
- R7: For single-cycle requests, the last window is checked only when its dual-cycle bit is 0.
- R8: When control bit 5 is set, single-cycle addresses from 0x80000 to 0xFFFFF hit no window.
- R9: When control bit 6 is set, dual-cycle addresses 0x100_0000_0000 to 0x1FF_FFFF_FFFF return address addr & 0x7_FFFF_FFFF with that same value as mask. Otherwise they fail.
- R10: Dual-cycle addresses 0x800_0000_0000 to 0xFFF_FFFF_FFFF use the last window's scatter-gather path when its dual-cycle and enable bits are both 1. The entry address is (tbase & 0x7_FFC0_0000) | ((addr & 0xFFFFE000)>>10).
- R11: A request with no hit returns rsp_ok_o=0, with rsp_addr_o=0 and rsp_mask_o=0.
- R12: req_ready_o is 0 from acceptance until the response is taken. A response holds, stable, until rsp_ready_i. mem_req_o and mem_addr_o hold until mem_rvalid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 2 | Register kind: 0 base, 1 mask, 2 translated base, 3 control |
| cfg_win_i | input | WIN_W | Window index for the write |
| cfg_wdata_i | input | 64 | Write data |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | ADDR_W | PCI DMA address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_ok_o | output | 1 | Translation permitted |
| rsp_addr_o | output | ADDR_W | Translated system address |
| rsp_mask_o | output | ADDR_W | Address bits covered by the translation |
| mem_req_o | output | 1 | Page table entry read request |
| mem_addr_o | output | PHYS_W | Entry address |
| mem_rvalid_i | input | 1 | Entry data valid |
| mem_rdata_i | input | 64 | Entry data |

## Verification
A direct window is tried with addresses inside and just outside its size mask. This tells the masked base compare apart from a plain equality compare. It also shows that low translated-base bits written as junk stay out of the result. Overlapping windows are enabled, then the winner is disabled, which separates priority from a simple OR of hits. The hole is tried on both sides of its lower edge, with the hole on and off. Scatter-gather is run for a single-cycle hit, for the last window with its forced scatter-gather bit, and for a dual-cycle hit. Each run uses a valid and an invalid entry, and each checks the exact entry address, which tells the two entry-address formulas apart. The large window is tried with its control bit off and on.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;
  localparam int ADDR_W  = 44;
  localparam int PHYS_W  = 35;
  localparam int SAC_W   = 32;
  localparam int PAGE_SH = 13;
  localparam int LO_W    = 20;
  localparam int TB_LO   = 10;

  typedef enum logic [1:0] {HIT_NONE, HIT_DIRECT, HIT_SG} hit_e;

  typedef struct packed {
    logic [SAC_W-LO_W-1:0]  base_hi;
    logic [SAC_W-LO_W-1:0]  mask_hi;
    logic [PHYS_W-TB_LO-1:0] tbase_hi;
    logic                   sg;
    logic                   en;
  } win_cfg_t;
endpackage

// File: rtl/dma_xlat_cfg.sv
module dma_xlat_cfg
  import dma_xlat_pkg::*;
#(
  parameter int NWIN = 4,
  localparam int WIN_W = $clog2(NWIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       kind_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic [63:0]      wdata_i,
  output win_cfg_t         win_o [NWIN],
  output logic             dac_o,
  output logic             hole_o,
  output logic             big_o
);
  localparam int LAST = NWIN - 1;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_o[w]    <= '0;
        win_o[w].sg <= (w == LAST);
      end else if (we_i && win_i == WIN_W'(w)) begin
        case (kind_i)
          2'd0: begin
            win_o[w].base_hi <= wdata_i[SAC_W-1:LO_W];
            win_o[w].sg      <= (w == LAST) ? 1'b1 : wdata_i[1];
            win_o[w].en      <= wdata_i[0];
          end
          2'd1: win_o[w].mask_hi  <= wdata_i[SAC_W-1:LO_W];
          2'd2: win_o[w].tbase_hi <= wdata_i[PHYS_W-1:TB_LO];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_o  <= 1'b0;
      hole_o <= 1'b0;
      big_o  <= 1'b0;
    end else if (we_i) begin
      if (kind_i == 2'd0 && win_i == WIN_W'(LAST)) dac_o <= wdata_i[39];
      if (kind_i == 2'd3) begin
        hole_o <= wdata_i[5];
        big_o  <= wdata_i[6];
      end
    end
  end
endmodule

// File: rtl/dma_xlat_match.sv
module dma_xlat_match
  import dma_xlat_pkg::*;
#(
  parameter int NWIN = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  win_cfg_t          win_i [NWIN],
  input  logic              dac_i,
  input  logic              hole_i,
  input  logic              big_i,
  output hit_e              kind_o,
  output logic [ADDR_W-1:0] xaddr_o,
  output logic [ADDR_W-1:0] xmask_o,
  output logic [PHYS_W-1:0] pte_o
);
  localparam int LAST = NWIN - 1;

  logic [NWIN-1:0]   hit_w;
  logic [PHYS_W-1:0] dir_w  [NWIN];
  logic [PHYS_W-1:0] ext_w  [NWIN];
  logic [PHYS_W-1:0] pte_w  [NWIN];

  wire [SAC_W-1:0] a32   = addr_i[SAC_W-1:0];
  wire             sac   = ~|addr_i[ADDR_W-1:SAC_W];
  wire             in_hole = hole_i && ~|a32[SAC_W-1:LO_W] && a32[LO_W-1];
  wire             big_rng = addr_i[ADDR_W-1:40] == 4'h1;
  wire             dac_rng = addr_i[ADDR_W-1];

  for (genvar w = 0; w < NWIN; w++) begin : g_cmp
    logic [PHYS_W-1:0] msk, ext, tb;
    always_comb begin
      msk = PHYS_W'({win_i[w].mask_hi, {LO_W{1'b0}}});
      ext = msk | PHYS_W'({LO_W{1'b1}});
      tb  = {win_i[w].tbase_hi, {TB_LO{1'b0}}};
      hit_w[w] = win_i[w].en &&
                 ((a32 & ~ext[SAC_W-1:0]) == {win_i[w].base_hi, {LO_W{1'b0}}});
      ext_w[w] = ext;
      dir_w[w] = (tb & ~ext) | (PHYS_W'(a32) & ext);
      pte_w[w] = (tb & ~(msk >> TB_LO)) |
                 ((PHYS_W'(a32) & (msk | PHYS_W'(20'hFE000))) >> TB_LO);
    end
  end

  always_comb begin
    kind_o  = HIT_NONE;
    xaddr_o = '0;
    xmask_o = '0;
    pte_o   = '0;
    if (sac) begin
      if (!in_hole) begin
        for (int w = LAST; w >= 0; w--) begin
          if (hit_w[w] && (w != LAST || !dac_i)) begin
            kind_o  = win_i[w].sg ? HIT_SG : HIT_DIRECT;
            xaddr_o = ADDR_W'(dir_w[w]);
            xmask_o = ADDR_W'(ext_w[w]);
            pte_o   = pte_w[w];
          end
        end
      end
    end else if (big_rng) begin
      if (big_i) begin
        kind_o  = HIT_DIRECT;
        xaddr_o = ADDR_W'(addr_i[PHYS_W-1:0]);
        xmask_o = ADDR_W'({PHYS_W{1'b1}});
      end
    end else if (dac_rng && dac_i && win_i[LAST].en) begin
      kind_o = HIT_SG;
      pte_o  = {win_i[LAST].tbase_hi[PHYS_W-TB_LO-1:12], a32[SAC_W-1:PAGE_SH], 3'b000};
    end
  end
endmodule

// File: rtl/dma_xlat_top.sv
module dma_xlat_top
  import dma_xlat_pkg::*;
#(
  parameter int NWIN = 4,
  localparam int WIN_W = $clog2(NWIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_kind_i,
  input  logic [WIN_W-1:0]  cfg_win_i,
  input  logic [63:0]       cfg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_ok_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [ADDR_W-1:0] rsp_mask_o,
  output logic              mem_req_o,
  output logic [PHYS_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i
);
  typedef enum logic [1:0] {S_IDLE, S_MATCH, S_FETCH, S_RESP} st_e;

  win_cfg_t          win_cfg [NWIN];
  logic              dac, hole, big;
  hit_e              m_kind;
  logic [ADDR_W-1:0] m_xaddr, m_xmask;
  logic [PHYS_W-1:0] m_pte;

  st_e               st;
  logic [ADDR_W-1:0] addr_q, xa_q, xm_q;
  logic [PHYS_W-1:0] pte_q;
  logic              ok_q;

  dma_xlat_cfg #(.NWIN(NWIN)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .kind_i(cfg_kind_i), .win_i(cfg_win_i),
    .wdata_i(cfg_wdata_i), .win_o(win_cfg), .dac_o(dac), .hole_o(hole), .big_o(big)
  );

  dma_xlat_match #(.NWIN(NWIN)) u_match (
    .addr_i(addr_q), .win_i(win_cfg), .dac_i(dac), .hole_i(hole), .big_i(big),
    .kind_o(m_kind), .xaddr_o(m_xaddr), .xmask_o(m_xmask), .pte_o(m_pte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= S_IDLE;
      addr_q <= '0;
      xa_q   <= '0;
      xm_q   <= '0;
      pte_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid_i) begin
          addr_q <= req_addr_i;
          st     <= S_MATCH;
        end
        S_MATCH: begin
          case (m_kind)
            HIT_DIRECT: begin
              ok_q <= 1'b1; xa_q <= m_xaddr; xm_q <= m_xmask; st <= S_RESP;
            end
            HIT_SG: begin
              pte_q <= m_pte; st <= S_FETCH;
            end
            default: begin
              ok_q <= 1'b0; xa_q <= '0; xm_q <= '0; st <= S_RESP;
            end
          endcase
        end
        S_FETCH: if (mem_rvalid_i) begin
          if (mem_rdata_i[0]) begin
            ok_q <= 1'b1;
            xa_q <= ADDR_W'({mem_rdata_i[21:1], addr_q[PAGE_SH-1:0]});
            xm_q <= ADDR_W'({PAGE_SH{1'b1}});
          end else begin
            ok_q <= 1'b0; xa_q <= '0; xm_q <= '0;
          end
          st <= S_RESP;
        end
        default: if (rsp_ready_i) st <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st == S_IDLE);
  assign rsp_valid_o = (st == S_RESP);
  assign rsp_ok_o    = ok_q;
  assign rsp_addr_o  = xa_q;
  assign rsp_mask_o  = xm_q;
  assign mem_req_o   = (st == S_FETCH);
  assign mem_addr_o  = pte_q;

  // R12: no new request while a response is pending
  assert_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  assert_rsp_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_ok_o));
  assert_mem_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));
  // R11: failed responses carry no address
  assert_fail_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ok_o |-> rsp_addr_o == '0 && rsp_mask_o == '0);
  // R4: entry addresses are 8-byte aligned
  assert_pte_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'b000);
endmodule

// File: tb/sim_dma_xlat_top.sv
module sim_dma_xlat_top;
  logic        clk_i = 0, rst_ni = 0;
  logic        cfg_we_i = 0;
  logic [1:0]  cfg_kind_i = 0;
  logic [1:0]  cfg_win_i = 0;
  logic [63:0] cfg_wdata_i = 0;
  logic        req_valid_i = 0, rsp_ready_i = 0, mem_rvalid_i = 0;
  logic [43:0] req_addr_i = 0;
  logic [63:0] mem_rdata_i = 0;
  logic        req_ready_o, rsp_valid_o, rsp_ok_o, mem_req_o;
  logic [43:0] rsp_addr_o, rsp_mask_o;
  logic [34:0] mem_addr_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  dma_xlat_top u0 (.*);

  task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int kind, input int win, input logic [63:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_kind_i = 2'(kind); cfg_win_i = 2'(win); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic xlat(input logic [43:0] a, input bit exp_fetch, input logic [34:0] exp_pte,
                      input logic [63:0] ent, input bit exp_ok, input logic [43:0] exp_a,
                      input logic [43:0] exp_m, input int hold, input string tag);
    bit fetched = 0, done = 0, busy = 0;
    @(negedge clk_i);
    req_valid_i = 1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 0;
    for (int n = 0; n < 30 && !done; n++) begin
      if (!req_ready_o) busy = 1;
      if (rsp_valid_o) begin
        logic [43:0] first = rsp_addr_o;
        for (int h = 0; h < hold; h++) begin
          @(negedge clk_i);
          chk(rsp_valid_o && rsp_addr_o == first && !req_ready_o,
              {tag, " R12 response hold"}, rsp_addr_o, first);
        end
        chk(rsp_ok_o == exp_ok, {tag, " ok"}, rsp_ok_o, exp_ok);
        chk(rsp_addr_o == exp_a, {tag, " addr"}, rsp_addr_o, exp_a);
        chk(rsp_mask_o == exp_m, {tag, " mask"}, rsp_mask_o, exp_m);
        rsp_ready_i = 1;
        @(negedge clk_i);
        rsp_ready_i = 0;
        done = 1;
      end else begin
        if (mem_req_o && !mem_rvalid_i) begin
          fetched = 1;
          chk(mem_addr_o == exp_pte, {tag, " entry address"}, mem_addr_o, exp_pte);
          mem_rvalid_i = 1; mem_rdata_i = ent;
        end else mem_rvalid_i = 0;
        @(negedge clk_i);
      end
    end
    mem_rvalid_i = 0;
    chk(done, {tag, " response seen"}, done, 1);
    chk(fetched == exp_fetch, {tag, " entry fetch"}, fetched, exp_fetch);
    chk(busy, {tag, " R12 ready low while busy"}, busy, 1);
    chk(req_ready_o, {tag, " R12 ready after response"}, req_ready_o, 1);
  endtask

  task automatic t_reset;
    chk(req_ready_o == 1, "R1 ready", req_ready_o, 1);
    chk(rsp_valid_o == 0, "R1 rsp_valid", rsp_valid_o, 0);
    chk(mem_req_o == 0, "R1 mem_req", mem_req_o, 0);
    xlat(44'h1234, 0, 0, 0, 0, 0, 0, 0, "R1 disabled windows");
    xlat(44'hC000_0000, 0, 0, 0, 0, 0, 0, 0, "R1 last window off");
  endtask

  task automatic t_direct;
    cfg_wr(0, 0, 64'h400F_FFF1);
    cfg_wr(1, 0, 64'h0010_0ABC);
    cfg_wr(2, 0, 64'h1_2340_03FF);
    xlat(44'h4015_6789, 0, 0, 0, 1, 44'h1_2355_6789, 44'h1F_FFFF, 2, "R3 R2 direct hit");
    xlat(44'h4035_6789, 0, 0, 0, 0, 0, 0, 0, "R11 R3 outside mask");
  endtask

  task automatic t_priority;
    cfg_wr(0, 1, 64'h4000_0001);
    cfg_wr(2, 1, 64'h2_0000_0000);
    xlat(44'h4005_6789, 0, 0, 0, 1, 44'h1_2345_6789, 44'h1F_FFFF, 0, "R6 window0 wins");
    cfg_wr(0, 0, 64'h0);
    xlat(44'h4005_6789, 0, 0, 0, 1, 44'h2_0005_6789, 44'hF_FFFF, 0, "R6 window1 next");
  endtask

  task automatic t_hole;
    cfg_wr(0, 2, 64'h1);
    cfg_wr(2, 2, 64'h3_0000_0000);
    xlat(44'h9_0000, 0, 0, 0, 1, 44'h3_0009_0000, 44'hF_FFFF, 0, "R8 hole off");
    cfg_wr(3, 0, 64'h20);
    xlat(44'h9_0000, 0, 0, 0, 0, 0, 0, 0, "R8 hole on");
    xlat(44'h8_0000, 0, 0, 0, 0, 0, 0, 0, "R8 hole low edge");
    xlat(44'h7_FFFF, 0, 0, 0, 1, 44'h3_0007_FFFF, 44'hF_FFFF, 0, "R8 below hole");
    cfg_wr(3, 0, 64'h0);
  endtask

  task automatic t_sg;
    cfg_wr(0, 1, 64'h8000_0003);
    cfg_wr(1, 1, 64'h0010_0000);
    cfg_wr(2, 1, 64'h500_0000);
    xlat(44'h8012_3456, 1, 35'h500_0488, 64'h2468B, 1, 44'h2468_B456, 44'h1FFF, 1, "R4 sg valid");
    xlat(44'h8012_3456, 1, 35'h500_0488, 64'h2468A, 0, 0, 0, 0, "R5 sg invalid");
  endtask

  task automatic t_last;
    cfg_wr(0, 3, 64'hC000_0001);
    cfg_wr(2, 3, 64'h600_0000);
    xlat(44'hC000_2345, 1, 35'h600_0008, 64'h3, 1, 44'h2345, 44'h1FFF, 0, "R7 R2 last window forced sg");
    cfg_wr(0, 3, 64'h80_C000_0001);
    xlat(44'hC000_2345, 0, 0, 0, 0, 0, 0, 0, "R7 dual bit blocks single cycle");
    xlat(44'h800_1234_5678, 1, 35'h604_8D10, 64'hEF, 1, 44'hE_F678, 44'h1FFF, 0, "R10 dual-cycle sg");
    xlat(44'h800_1234_5678, 1, 35'h604_8D10, 64'hEE, 0, 0, 0, 0, "R10 R5 dual-cycle invalid");
    cfg_wr(0, 3, 64'h80_0000_0000);
    xlat(44'h800_1234_5678, 0, 0, 0, 0, 0, 0, 0, "R10 last window disabled");
  endtask

  task automatic t_big;
    xlat(44'h1AB_CDEF_0123, 0, 0, 0, 0, 0, 0, 0, "R9 large window off");
    cfg_wr(3, 0, 64'h40);
    xlat(44'h1AB_CDEF_0123, 0, 0, 0, 1, 44'h3_CDEF_0123, 44'h7_FFFF_FFFF, 0, "R9 large window on");
    xlat(44'h200_0000_0000, 0, 0, 0, 0, 0, 0, 0, "R11 dual-cycle miss");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset;
    t_direct;
    t_priority;
    t_hole;
    t_sg;
    t_last;
    t_big;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule